// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates seven interrupt sources for a small processor core: two external active-low pins, the overflow flags of three timers, a serial-port flag and a two-wire bus flag. A master enable and one enable bit per source mask the pending requests. A fixed priority order picks one winner, and the block presents the winner's vector address to the core together with a request line.

Each external pin passes through a two-flop synchronizer. A per-pin type input selects how the pin is read. In edge mode a falling edge sets a latched flag. In level mode a low pin requests directly and nothing is latched. The block owns the external edge flags and the timer0 and timer1 overflow flags, and clears them when the core takes their vector. The serial, bus and timer2 flags come in as levels, and software clears them elsewhere.

The core handshakes with two pulses. `ack` takes the presented vector and marks a handler active, which hides further requests. `ret` ends the active state.

Top module: `irq_vector_arbiter`

## Requirements
- R1: While `enableReg[7]` (master enable) is 0, `irqReq` stays 0 whatever the sources do.
- R2: While the master enable is 1, a source can request only when its own enable bit is 1. The bits are: [6] timer2, [5] bus, [4] serial, [3] timer1, [2] ext1, [1] timer0, [0] ext0.
- R3: Among the enabled pending sources, the one highest in this order wins: ext0, bus, timer0, ext1, timer1, serial, timer2.
- R4: The `reqVector` of the winner is ext0 0x0003, timer0 0x000B, ext1 0x0013, timer1 0x001B, serial 0x0023, bus 0x002B, timer2 0x0033.
- R5: With `extType[n]`=1 (edge mode), a 1-to-0 change on `extPinN[n]` sets `extFlag[n]` at the third rising clock edge after the change, not earlier. The flag stays set after the pin returns high.
- R6: Taking the vector of an edge-mode external source clears its `extFlag` at that clock edge.
- R7: With `extType[n]`=0 (level mode), the pin requests from the second rising edge after it goes low, and stops requesting two edges after it goes high. `extFlag[n]` stays 0.
- R8: A `tmrNSet` pulse sets `tmrNFlag` (N = 0, 1) at the next edge. Taking that timer's vector clears the flag. If a set pulse and the clearing take fall in the same cycle, the flag stays set.
- R9: The serial, bus and timer2 inputs keep requesting after their vector has been taken and the handler has returned.
- R10: `irqReq` is 1 only while `handlerActive` is 0. An `ack` with `irqReq`=1 sets `handlerActive` and loads `activeVector` with `reqVector` at that edge. An `ack` with `irqReq`=0 has no effect. A `ret` while active clears `handlerActive`.
- R11: After reset, `irqReq`, `handlerActive`, `activeVector`, `extFlag`, `tmr0Flag` and `tmr1Flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| extPinN | input | 2 | External interrupt pins, active low, asynchronous |
| extType | input | 2 | Per-pin mode: 1 falling edge, 0 low level |
| enableReg | input | 8 | Master enable [7] and per-source enables [6:0] |
| tmr0Set | input | 1 | Timer0 overflow pulse |
| tmr1Set | input | 1 | Timer1 overflow pulse |
| serialFlag | input | 1 | Serial receive-or-transmit flag, level |
| busFlag | input | 1 | Two-wire bus flag, level |
| tmr2Flag | input | 1 | Timer2 overflow-or-external flag, level |
| ack | input | 1 | Core takes the presented vector |
| ret | input | 1 | Core returns from the handler |
| irqReq | output | 1 | Request to the core |
| reqVector | output | 16 | Vector of the current winner |
| handlerActive | output | 1 | A handler is in progress |
| activeVector | output | 16 | Vector taken by the last accepted ack |
| extFlag | output | 2 | Latched edge flags of the external pins |
| tmr0Flag | output | 1 | Timer0 overflow flag |
| tmr1Flag | output | 1 | Timer1 overflow flag |

## Verification
Two events can fall in the same cycle: a timer overflow pulse, and the accepted `ack` that clears that same timer's flag. The new event must survive, so the flag must read 1 after the edge. A directed case drives `tmr0Set` and `ack` together while timer0 is the winner, and checks the flag, `handlerActive` and `activeVector` after that edge. The random phase also draws overflow pulses and acks independently in every cycle, which makes the collision happen many times. A bench model that applies set-over-clear judges each cycle's flags, request and vector.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSRC = 7;
  localparam int CODE_W = 3;

  // code of each source equals its enable bit index
  localparam logic [CODE_W-1:0] CODE_EXT0 = 3'd0;
  localparam logic [CODE_W-1:0] CODE_TMR0 = 3'd1;
  localparam logic [CODE_W-1:0] CODE_EXT1 = 3'd2;
  localparam logic [CODE_W-1:0] CODE_TMR1 = 3'd3;
  localparam logic [CODE_W-1:0] CODE_SER  = 3'd4;
  localparam logic [CODE_W-1:0] CODE_BUS  = 3'd5;
  localparam logic [CODE_W-1:0] CODE_TMR2 = 3'd6;

  typedef struct packed {
    logic              take;
    logic [NSRC-1:0]   grant;
    logic [CODE_W-1:0] winCode;
  } strobe_t;

  // rank 0 is the highest priority
  function automatic logic [CODE_W-1:0] rankToCode(input int rank);
    case (rank)
      0: rankToCode = CODE_EXT0;
      1: rankToCode = CODE_BUS;
      2: rankToCode = CODE_TMR0;
      3: rankToCode = CODE_EXT1;
      4: rankToCode = CODE_TMR1;
      5: rankToCode = CODE_SER;
      default: rankToCode = CODE_TMR2;
    endcase
  endfunction
endpackage

// File: rtl/intc_control.sv
module intc_control
  import intc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC:0]   enableReg,
  input  logic [NSRC-1:0] rawReq,
  input  logic            ack,
  input  logic            ret,
  output strobe_t         strobes,
  output logic            irqReq,
  output logic            handlerActive
);
  logic [NSRC-1:0]   masked;
  logic [NSRC-1:0]   grant;
  logic [CODE_W-1:0] winCode;
  logic              found;
  logic              take;
  logic              release_;

  assign masked = rawReq & enableReg[NSRC-1:0] & {NSRC{enableReg[NSRC]}};

  always_comb begin
    grant   = '0;
    winCode = '0;
    found   = 1'b0;
    for (int r = 0; r < NSRC; r++) begin
      if (!found && masked[rankToCode(r)]) begin
        found              = 1'b1;
        grant[rankToCode(r)] = 1'b1;
        winCode            = rankToCode(r);
      end
    end
  end

  assign irqReq   = found && !handlerActive;
  assign take     = ack && irqReq;
  assign release_ = ret && handlerActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         handlerActive <= 1'b0;
    else if (take)     handlerActive <= 1'b1;
    else if (release_) handlerActive <= 1'b0;
  end

  assign strobes = '{take: take, grant: grant, winCode: winCode};

  // R1
  master_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> enableReg[NSRC]);
  // R2
  source_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.take |-> (rawReq[strobes.winCode] && enableReg[strobes.winCode]));
  // R10
  take_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.take |=> handlerActive);
  // R10
  ret_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ret && handlerActive) |=> !handlerActive);
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int VEC_W       = 16,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STRIDE  = 8,
  parameter int SYNC_STAGES = 2,
  parameter int NEXT        = 2
)(
  input  logic            clk,
  input  logic            rstN,
  input  logic [NEXT-1:0] extPinN,
  input  logic [NEXT-1:0] extType,
  input  logic            tmr0Set,
  input  logic            tmr1Set,
  input  logic            serialFlag,
  input  logic            busFlag,
  input  logic            tmr2Flag,
  input  strobe_t         strobes,
  output logic [NSRC-1:0] rawReq,
  output logic [VEC_W-1:0] reqVector,
  output logic [VEC_W-1:0] activeVector,
  output logic [NEXT-1:0] extFlag,
  output logic            tmr0Flag,
  output logic            tmr1Flag
);
  logic [NEXT-1:0] extReq;
  logic [1:0]      tmrSet;
  logic [1:0]      tmrQ;

  for (genvar g = 0; g < NEXT; g++) begin : g_ext
    localparam int CODE = 2 * g;
    logic [SYNC_STAGES:0] chain;
    logic syncd, prevQ, fall, flagQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-1:0], extPinN[g]};
    end
    assign syncd = chain[SYNC_STAGES-1];
    assign prevQ = chain[SYNC_STAGES];
    assign fall  = prevQ && !syncd;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  flagQ <= 1'b0;
      else if (!extType[g])                       flagQ <= 1'b0;
      else if (fall)                              flagQ <= 1'b1;
      else if (strobes.take && strobes.grant[CODE]) flagQ <= 1'b0;
    end

    assign extFlag[g] = flagQ;
    assign extReq[g]  = extType[g] ? flagQ : !syncd;

    // R5
    edge_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      (extType[g] && fall) |=> flagQ);
    // R7
    level_noflag_chk: assert property (@(posedge clk) disable iff (!rstN)
      !extType[g] |=> !flagQ);
  end

  assign tmrSet = {tmr1Set, tmr0Set};

  for (genvar t = 0; t < 2; t++) begin : g_tmr
    localparam int CODE = 2 * t + 1;
    logic flagQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagQ <= 1'b0;
      else       flagQ <= tmrSet[t] || (flagQ && !(strobes.take && strobes.grant[CODE]));
    end
    assign tmrQ[t] = flagQ;

    // R8
    tmr_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      tmrSet[t] |=> flagQ);
    // R8
    tmr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.take && strobes.grant[CODE] && !tmrSet[t]) |=> !flagQ);
  end

  assign tmr0Flag = tmrQ[0];
  assign tmr1Flag = tmrQ[1];

  assign rawReq = {tmr2Flag, busFlag, serialFlag, tmrQ[1], extReq[1], tmrQ[0], extReq[0]};

  assign reqVector = VEC_W'(VEC_BASE + VEC_STRIDE * int'(strobes.winCode));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             activeVector <= '0;
    else if (strobes.take) activeVector <= reqVector;
  end

  // R10
  vec_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.take |=> (activeVector == $past(reqVector)));
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
  import intc_pkg::*;
#(
  parameter int VEC_W       = 16,
  parameter int SYNC_STAGES = 2
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       extPinN,
  input  logic [1:0]       extType,
  input  logic [7:0]       enableReg,
  input  logic             tmr0Set,
  input  logic             tmr1Set,
  input  logic             serialFlag,
  input  logic             busFlag,
  input  logic             tmr2Flag,
  input  logic             ack,
  input  logic             ret,
  output logic             irqReq,
  output logic [VEC_W-1:0] reqVector,
  output logic             handlerActive,
  output logic [VEC_W-1:0] activeVector,
  output logic [1:0]       extFlag,
  output logic             tmr0Flag,
  output logic             tmr1Flag
);
  strobe_t         strobes;
  logic [NSRC-1:0] rawReq;

  intc_control u_control (
    .clk(clk), .rstN(rstN), .enableReg(enableReg), .rawReq(rawReq),
    .ack(ack), .ret(ret), .strobes(strobes), .irqReq(irqReq),
    .handlerActive(handlerActive)
  );

  intc_datapath #(.VEC_W(VEC_W), .SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk(clk), .rstN(rstN), .extPinN(extPinN), .extType(extType),
    .tmr0Set(tmr0Set), .tmr1Set(tmr1Set), .serialFlag(serialFlag),
    .busFlag(busFlag), .tmr2Flag(tmr2Flag), .strobes(strobes),
    .rawReq(rawReq), .reqVector(reqVector), .activeVector(activeVector),
    .extFlag(extFlag), .tmr0Flag(tmr0Flag), .tmr1Flag(tmr1Flag)
  );
endmodule

// File: tb/test_irq_vector_arbiter.sv
`timescale 1ns/1ps
module test_irq_vector_arbiter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] extPinN = 2'b11, extType = 2'b00;
  logic [7:0] enableReg = 8'h00;
  logic tmr0Set = 0, tmr1Set = 0, serialFlag = 0, busFlag = 0, tmr2Flag = 0, ack = 0, ret = 0;
  logic irqReq, handlerActive, tmr0Flag, tmr1Flag;
  logic [15:0] reqVector, activeVector;
  logic [1:0] extFlag;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_vector_arbiter i_irq_vector_arbiter (
    .clk(clk), .rstN(rstN), .extPinN(extPinN), .extType(extType), .enableReg(enableReg),
    .tmr0Set(tmr0Set), .tmr1Set(tmr1Set), .serialFlag(serialFlag), .busFlag(busFlag),
    .tmr2Flag(tmr2Flag), .ack(ack), .ret(ret), .irqReq(irqReq), .reqVector(reqVector),
    .handlerActive(handlerActive), .activeVector(activeVector), .extFlag(extFlag),
    .tmr0Flag(tmr0Flag), .tmr1Flag(tmr1Flag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // source codes = enable bit index; priority ranks listed high to low
  function automatic int rankCode(input int r);
    int order[7] = '{0, 5, 1, 2, 3, 4, 6};
    return order[r];
  endfunction

  function automatic int winnerOf(input logic [7:0] en, input logic [6:0] pend);
    if (!en[7]) return 7;
    for (int r = 0; r < 7; r++)
      if (pend[rankCode(r)] && en[rankCode(r)]) return rankCode(r);
    return 7;
  endfunction

  function automatic logic [15:0] vecOf(input int code);
    return 16'(3 + 8 * code);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seedSink;
    logic mT0, mT1, mAct;
    logic [15:0] mVec;
    seedSink = $urandom(32'h5eed_1c01);
    repeat (3) tick();
    // R11 reset state
    check("R11 irqReq", irqReq, 0);
    check("R11 handlerActive", handlerActive, 0);
    check("R11 activeVector", activeVector, 0);
    check("R11 extFlag", extFlag, 0);
    check("R11 tmrFlags", {tmr1Flag, tmr0Flag}, 0);
    rstN = 1'b1;
    tick();

    // R1 master enable off blocks all
    enableReg = 8'h7F; serialFlag = 1; busFlag = 1; tmr2Flag = 1; #1;
    check("R1 master off", irqReq, 0);
    // R2 per-source gate: only timer2 enabled
    enableReg = 8'hC0; #1;
    check("R2 only timer2", irqReq, 1);
    check("R4 timer2 vector", reqVector, 16'h0033);
    enableReg = 8'h80; #1;
    check("R2 none enabled", irqReq, 0);
    serialFlag = 0; tmr2Flag = 0;

    // R5 edge on ext0 with bus also pending; R3 ext0 outranks bus
    extType = 2'b01; enableReg = 8'hFF; busFlag = 1;
    extPinN[0] = 1'b0;
    tick(); tick();
    check("R5 flag not before third edge", extFlag[0], 0);
    check("R3 bus wins before ext0 flag", reqVector, 16'h002B);
    tick();
    check("R5 flag at third edge", extFlag[0], 1);
    extPinN[0] = 1'b1;
    tick(); tick(); tick();
    check("R5 flag held after pin high", extFlag[0], 1);
    check("R3 ext0 highest", reqVector, 16'h0003);
    // R10 ack takes ext0
    ack = 1; tick(); ack = 0;
    check("R6 edge flag cleared", extFlag[0], 0);
    check("R10 active", handlerActive, 1);
    check("R10 activeVector", activeVector, 16'h0003);
    check("R10 no req while active", irqReq, 0);
    ret = 1; tick(); ret = 0;
    check("R10 ret clears active", handlerActive, 0);
    check("R3 bus next", reqVector, 16'h002B);
    busFlag = 0;

    // R7 level mode on ext1
    extType = 2'b00; enableReg = 8'h84;
    extPinN[1] = 1'b0;
    tick();
    check("R7 not after one edge", irqReq, 0);
    tick();
    check("R7 level request", irqReq, 1);
    check("R4 ext1 vector", reqVector, 16'h0013);
    check("R7 no latch", extFlag[1], 0);
    extPinN[1] = 1'b1;
    tick(); tick();
    check("R7 request follows pin", irqReq, 0);

    // R10 ack without request has no effect
    ack = 1; tick(); ack = 0;
    check("R10 idle ack ignored", handlerActive, 0);

    // R8 set wins over clear in same cycle
    enableReg = 8'h82; tmr0Set = 1; tick(); tmr0Set = 0;
    check("R8 set", tmr0Flag, 1);
    check("R4 timer0 vector", reqVector, 16'h000B);
    ack = 1; tmr0Set = 1; tick(); ack = 0; tmr0Set = 0;
    check("R8 set beats clear", tmr0Flag, 1);
    check("R10 activeVector timer0", activeVector, 16'h000B);
    ret = 1; tick(); ret = 0;
    ack = 1; tick(); ack = 0;
    check("R8 cleared on take", tmr0Flag, 0);
    ret = 1; tick(); ret = 0;

    // R9 serial persists through take and return
    enableReg = 8'h90; serialFlag = 1; #1;
    check("R4 serial vector", reqVector, 16'h0023);
    ack = 1; tick(); ack = 0;
    ret = 1; tick(); ret = 0;
    check("R9 serial still requests", irqReq, 1);
    check("R9 serial vector", reqVector, 16'h0023);
    serialFlag = 0;

    // random phase against model; ext pins idle high
    mT0 = tmr0Flag; mT1 = tmr1Flag; mAct = handlerActive; mVec = activeVector;
    for (int i = 0; i < 3000; i++) begin
      int win;
      logic expReq, take;
      enableReg  = {($urandom % 4) != 0, 7'($urandom)};
      extType    = 2'($urandom);
      serialFlag = 1'($urandom); busFlag = 1'($urandom); tmr2Flag = 1'($urandom);
      tmr0Set = ($urandom % 8) == 0; tmr1Set = ($urandom % 8) == 0;
      ack = ($urandom % 4) == 0; ret = ($urandom % 4) == 0;
      #1;
      win = winnerOf(enableReg, {tmr2Flag, busFlag, serialFlag, mT1, 1'b0, mT0, 1'b0});
      expReq = (win != 7) && !mAct;
      check("R3 random irqReq", irqReq, expReq);
      if (expReq) check("R4 random vector", reqVector, vecOf(win));
      take = ack && expReq;
      mT0 = tmr0Set | (mT0 & !(take && win == 1));
      mT1 = tmr1Set | (mT1 & !(take && win == 3));
      if (take) begin mAct = 1; mVec = vecOf(win); end
      else if (ret && mAct) mAct = 0;
      tick();
      check("R8 random tmr0Flag", tmr0Flag, mT0);
      check("R8 random tmr1Flag", tmr1Flag, mT1);
      check("R10 random active", handlerActive, mAct);
      check("R10 random activeVector", activeVector, mVec);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule